// File: doc/BRIEF.md
# Partial-Word Load/Store Alignment Unit

This unit sits between a 64-bit data memory and the register file. For a load, it takes the fetched memory word and picks out the addressed field. That field is a single byte, a quarter word, a half word or the whole word. The unit moves the field down to bit 0, then either sign-extends it or fills the upper bits with zeros. It also chooses the access state (full or empty) that goes with the value into the destination register.

For a store, the unit takes the old memory word and replaces only the addressed field with the low bits of the source value. All other bits of the old word are kept. The unit also raises a flag that tells the memory to skip error-correction for one particular whole-word code.

The field selector, the byte-mode flag and the two access flags can come from two places: the instruction, or a designated control register. A source-select input chooses between them. Every result is registered and appears one clock after the request.

Top module: `pw_align_unit`

## Requirements
- R1: While reset is held, and right after it, `res_valid_o`, `res_store_o`, `load_full_o`, `skip_ecc_o`, `load_data_o` and `merged_o` are all zero.
- R2: With byte mode set, the 3-bit code N selects memory bits [8N+7:8N] (code 0 → bits 7:0, code 7 → bits 63:56).
- R3: Without byte mode, code 0 selects bits 63:0, code 1 selects bits 15:0, code 2 selects bits 31:0 and code 3 selects bits 31:16.
- R4: Without byte mode, code 4 selects bits 63:0, code 5 selects bits 47:32, code 6 selects bits 63:32 and code 7 selects bits 63:48.
- R5: On a load, the selected field is right-justified in `load_data_o`. With the sign flag set, its top bit fills all higher bits; with the sign flag clear, the higher bits are zero.
- R6: On a load, with the copy flag set, `load_full_o` equals the memory word's state input `mem_full_i`; with the copy flag clear, `load_full_o` is 1 (full).
- R7: When `src_creg_i` is 1, the code, byte mode, sign flag and copy flag are all taken from the `creg_*` inputs; when it is 0, they are taken from the `insn_*` inputs.
- R8: On a store, `merged_o` equals the old word with only the selected field replaced by the low bits of `store_data_i`; every other bit is unchanged.
- R9: `skip_ecc_o` is 1 only for a valid request with code 4 and byte mode clear; it is 0 for every other code and mode.
- R10: Results appear exactly one clock after the request edge. `res_valid_o` is high for one cycle for each request, and `res_store_o` shows whether that request was a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Request strobe |
| op_store_i | input | 1 | 1 = store merge, 0 = load extract |
| src_creg_i | input | 1 | Take the selector and flags from the control register inputs |
| insn_code_i | input | 3 | Field code from the instruction |
| insn_byte_i | input | 1 | Byte mode from the instruction |
| insn_sext_i | input | 1 | Sign-extend flag from the instruction |
| insn_copy_i | input | 1 | Copy-state flag from the instruction |
| creg_code_i | input | 3 | Field code from the control register |
| creg_byte_i | input | 1 | Byte mode from the control register |
| creg_sext_i | input | 1 | Sign-extend flag from the control register |
| creg_copy_i | input | 1 | Copy-state flag from the control register |
| mem_word_i | input | 64 | Word read from data memory |
| mem_full_i | input | 1 | Access state of the memory word (1 = full) |
| store_data_i | input | 64 | Source value for a store |
| res_valid_o | output | 1 | Result valid, one cycle after the request |
| res_store_o | output | 1 | The result belongs to a store |
| load_data_o | output | 64 | Extracted and extended load value |
| load_full_o | output | 1 | Access state for the destination register |
| merged_o | output | 64 | Old word with the selected field replaced |
| skip_ecc_o | output | 1 | Skip error-correction for this access |

## Verification
The bench runs every code in both byte mode and word mode, using a memory word in which each byte has a different value and its top bit set. A decoder that confuses code 3 with code 5, or that places quarter word 3 at bits 47:32, produces a clearly wrong value.

Sign extension is tested on fields whose top bit is set and on fields whose top bit is clear. A unit that extends from the wrong bit, or that extends even when the sign flag is off, shows stray ones in the upper bits.

Stores are checked with an old word of all ones and a source value of all zeros, and the other way round. A merge that touches a neighbouring byte lane changes a bit that must stay the same.

The control-register path is given values that differ from the instruction values. A wrong source mux then picks a different field, sign flag or access state. The ECC-skip flag is checked for every code in both modes.

// File: rtl/pw_align_pkg.sv
package pw_align_pkg;

    localparam int CODE_W = 3;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              byte_m;
        logic              sext;
        logic              copy;
    } pw_ctl_t;

    localparam logic [CODE_W-1:0] CODE_WORD_NOECC = 3'd4;

endpackage

// File: rtl/pw_field_decode.sv
module pw_field_decode
    import pw_align_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    localparam int NLANES = DATA_W / LANE_W,
    localparam int OFF_W  = $clog2(NLANES)
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              byte_i,
    output logic [OFF_W-1:0]  lane_off_o,
    output logic [NLANES-1:0] keep_o,
    output logic              no_ecc_o
);
    localparam int QL = NLANES / 4;
    localparam int HL = NLANES / 2;

    function automatic logic [NLANES-1:0] low_ones(input int n);
        return {NLANES{1'b1}} >> (NLANES - n);
    endfunction

    always_comb begin
        lane_off_o = '0;
        keep_o     = low_ones(NLANES);
        no_ecc_o   = 1'b0;
        if (byte_i) begin
            lane_off_o = OFF_W'(code_i);
            keep_o     = low_ones(1);
        end else begin
            case (code_i)
                3'd0: begin lane_off_o = '0;            keep_o = low_ones(NLANES); end
                3'd1: begin lane_off_o = '0;            keep_o = low_ones(QL);     end
                3'd2: begin lane_off_o = '0;            keep_o = low_ones(HL);     end
                3'd3: begin lane_off_o = OFF_W'(QL);    keep_o = low_ones(QL);     end
                3'd4: begin lane_off_o = '0;            keep_o = low_ones(NLANES);
                            no_ecc_o   = 1'b1;                                     end
                3'd5: begin lane_off_o = OFF_W'(HL);    keep_o = low_ones(QL);     end
                3'd6: begin lane_off_o = OFF_W'(HL);    keep_o = low_ones(HL);     end
                default: begin lane_off_o = OFF_W'(3*QL); keep_o = low_ones(QL);   end
            endcase
        end
    end

    always_comb begin
        if (!byte_i && code_i == CODE_WORD_NOECC)
            assert (no_ecc_o && lane_off_o == '0);   // R9
    end

endmodule

// File: rtl/pw_load_extract.sv
module pw_load_extract #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    localparam int NLANES = DATA_W / LANE_W,
    localparam int OFF_W  = $clog2(NLANES),
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] mem_i,
    input  logic [OFF_W-1:0]  lane_off_i,
    input  logic [NLANES-1:0] keep_i,
    input  logic              sext_i,
    input  logic              copy_i,
    input  logic              mem_full_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o
);
    logic [SH_W-1:0]   sh_amt;
    logic [DATA_W-1:0] shifted;
    logic              sign_bit;
    logic              fill;

    assign sh_amt  = SH_W'(lane_off_i) * SH_W'(LANE_W);
    assign shifted = mem_i >> sh_amt;

    always_comb begin
        sign_bit = 1'b0;
        for (int i = 0; i < NLANES; i++) begin
            if (keep_i[i]) sign_bit = shifted[i*LANE_W + LANE_W - 1];
        end
    end

    assign fill = sext_i & sign_bit;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign data_o[g*LANE_W +: LANE_W] = keep_i[g] ? shifted[g*LANE_W +: LANE_W]
                                                      : {LANE_W{fill}};
    end

    assign full_o = copy_i ? mem_full_i : 1'b1;

endmodule

// File: rtl/pw_store_merge.sv
module pw_store_merge #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    localparam int NLANES = DATA_W / LANE_W,
    localparam int OFF_W  = $clog2(NLANES),
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [OFF_W-1:0]  lane_off_i,
    input  logic [NLANES-1:0] keep_i,
    output logic [DATA_W-1:0] merged_o
);
    logic [SH_W-1:0]   sh_amt;
    logic [DATA_W-1:0] placed;
    logic [NLANES-1:0] lane_en;

    assign sh_amt  = SH_W'(lane_off_i) * SH_W'(LANE_W);
    assign placed  = src_i << sh_amt;
    assign lane_en = keep_i << lane_off_i;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign merged_o[g*LANE_W +: LANE_W] = lane_en[g] ? placed[g*LANE_W +: LANE_W]
                                                         : old_i[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/pw_align_unit.sv
module pw_align_unit
    import pw_align_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    localparam int NLANES = DATA_W / LANE_W,
    localparam int OFF_W  = $clog2(NLANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic              op_store_i,
    input  logic              src_creg_i,
    input  logic [2:0]        insn_code_i,
    input  logic              insn_byte_i,
    input  logic              insn_sext_i,
    input  logic              insn_copy_i,
    input  logic [2:0]        creg_code_i,
    input  logic              creg_byte_i,
    input  logic              creg_sext_i,
    input  logic              creg_copy_i,
    input  logic [DATA_W-1:0] mem_word_i,
    input  logic              mem_full_i,
    input  logic [DATA_W-1:0] store_data_i,
    output logic              res_valid_o,
    output logic              res_store_o,
    output logic [DATA_W-1:0] load_data_o,
    output logic              load_full_o,
    output logic [DATA_W-1:0] merged_o,
    output logic              skip_ecc_o
);
    typedef struct packed {
        logic              valid;
        logic              store;
        logic [DATA_W-1:0] ldata;
        logic              lfull;
        logic [DATA_W-1:0] merged;
        logic              no_ecc;
    } res_t;

    res_t    res_d, res_q;
    pw_ctl_t ctl_insn, ctl_creg, ctl_sel;

    logic [OFF_W-1:0]  lane_off;
    logic [NLANES-1:0] keep;
    logic              no_ecc;
    logic [DATA_W-1:0] ext_data;
    logic              ext_full;
    logic [DATA_W-1:0] mrg_word;

    assign ctl_insn = '{code: insn_code_i, byte_m: insn_byte_i, sext: insn_sext_i, copy: insn_copy_i};
    assign ctl_creg = '{code: creg_code_i, byte_m: creg_byte_i, sext: creg_sext_i, copy: creg_copy_i};
    assign ctl_sel  = src_creg_i ? ctl_creg : ctl_insn;

    pw_field_decode #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_dec (
        .code_i     (ctl_sel.code),
        .byte_i     (ctl_sel.byte_m),
        .lane_off_o (lane_off),
        .keep_o     (keep),
        .no_ecc_o   (no_ecc)
    );

    pw_load_extract #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_ld (
        .mem_i      (mem_word_i),
        .lane_off_i (lane_off),
        .keep_i     (keep),
        .sext_i     (ctl_sel.sext),
        .copy_i     (ctl_sel.copy),
        .mem_full_i (mem_full_i),
        .data_o     (ext_data),
        .full_o     (ext_full)
    );

    pw_store_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_st (
        .old_i      (mem_word_i),
        .src_i      (store_data_i),
        .lane_off_i (lane_off),
        .keep_i     (keep),
        .merged_o   (mrg_word)
    );

    always_comb begin
        res_d        = res_q;
        res_d.valid  = op_valid_i;
        res_d.store  = op_valid_i & op_store_i;
        res_d.no_ecc = op_valid_i & no_ecc;
        if (op_valid_i) begin
            res_d.ldata  = ext_data;
            res_d.lfull  = ext_full;
            res_d.merged = mrg_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid_o = res_q.valid;
    assign res_store_o = res_q.store;
    assign load_data_o = res_q.ldata;
    assign load_full_o = res_q.lfull;
    assign merged_o    = res_q.merged;
    assign skip_ecc_o  = res_q.no_ecc;

    AST_ECC_SKIP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        skip_ecc_o |-> ($past(ctl_sel.code) == 3'd4 && !$past(ctl_sel.byte_m) && res_valid_o)); // R9

    AST_FULL_NO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !$past(ctl_sel.copy)) |-> load_full_o); // R6

    AST_BYTE_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_store_o && $past(ctl_sel.byte_m) && !$past(ctl_sel.sext))
        |-> (load_data_o[DATA_W-1:LANE_W] == '0)); // R5

    AST_BYTE_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_store_o && $past(ctl_sel.byte_m) && $past(ctl_sel.sext)
         && load_data_o[LANE_W-1])
        |-> (&load_data_o[DATA_W-1:LANE_W])); // R5

    AST_STORE_KEEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (res_store_o && $past(ctl_sel.code) == 3'd1 && !$past(ctl_sel.byte_m))
        |-> (merged_o[DATA_W-1:DATA_W/4] == $past(mem_word_i[DATA_W-1:DATA_W/4]))); // R8

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_store_o |-> res_valid_o); // R10

endmodule

// File: tb/pw_align_unit_tb_top.sv
`timescale 1ns/1ps
module pw_align_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid_i, op_store_i, src_creg_i;
    logic [2:0]  insn_code_i, creg_code_i;
    logic        insn_byte_i, insn_sext_i, insn_copy_i;
    logic        creg_byte_i, creg_sext_i, creg_copy_i;
    logic [63:0] mem_word_i, store_data_i;
    logic        mem_full_i;
    logic        res_valid_o, res_store_o, load_full_o, skip_ecc_o;
    logic [63:0] load_data_o, merged_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pw_align_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .op_valid_i(op_valid_i), .op_store_i(op_store_i), .src_creg_i(src_creg_i),
        .insn_code_i(insn_code_i), .insn_byte_i(insn_byte_i),
        .insn_sext_i(insn_sext_i), .insn_copy_i(insn_copy_i),
        .creg_code_i(creg_code_i), .creg_byte_i(creg_byte_i),
        .creg_sext_i(creg_sext_i), .creg_copy_i(creg_copy_i),
        .mem_word_i(mem_word_i), .mem_full_i(mem_full_i), .store_data_i(store_data_i),
        .res_valid_o(res_valid_o), .res_store_o(res_store_o),
        .load_data_o(load_data_o), .load_full_o(load_full_o),
        .merged_o(merged_o), .skip_ecc_o(skip_ecc_o)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic void field_of(input logic [2:0] c, input bit bm,
                                     output int off, output int w, output bit ne);
        ne = 0;
        if (bm) begin off = c * 8; w = 8; end
        else begin
            case (c)
                3'd0: begin off = 0;  w = 64; end
                3'd1: begin off = 0;  w = 16; end
                3'd2: begin off = 0;  w = 32; end
                3'd3: begin off = 16; w = 16; end
                3'd4: begin off = 0;  w = 64; ne = 1; end
                3'd5: begin off = 32; w = 16; end
                3'd6: begin off = 32; w = 32; end
                default: begin off = 48; w = 16; end
            endcase
        end
    endfunction

    function automatic logic [63:0] mask_of(input int w);
        return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    endfunction

    task automatic idle();
        op_valid_i = 0; op_store_i = 0; src_creg_i = 0;
        insn_code_i = 0; insn_byte_i = 0; insn_sext_i = 0; insn_copy_i = 0;
        creg_code_i = 0; creg_byte_i = 0; creg_sext_i = 0; creg_copy_i = 0;
        mem_word_i = 0; mem_full_i = 0; store_data_i = 0;
    endtask

    // Issues one request at a negedge; checks the registered result one cycle later.
    task automatic run_op(input string req, input bit st, input bit use_creg,
                          input logic [2:0] ic, input bit ib, input bit is, input bit icp,
                          input logic [2:0] cc, input bit cb, input bit cs, input bit ccp,
                          input logic [63:0] mw, input bit mf, input logic [63:0] sd);
        int off, w; bit ne;
        logic [63:0] m, f, exp_mrg;
        logic [2:0] c; bit b, s, cp;
        @(negedge clk);
        op_valid_i = 1; op_store_i = st; src_creg_i = use_creg;
        insn_code_i = ic; insn_byte_i = ib; insn_sext_i = is; insn_copy_i = icp;
        creg_code_i = cc; creg_byte_i = cb; creg_sext_i = cs; creg_copy_i = ccp;
        mem_word_i = mw; mem_full_i = mf; store_data_i = sd;
        c = use_creg ? cc : ic; b = use_creg ? cb : ib;
        s = use_creg ? cs : is; cp = use_creg ? ccp : icp;
        field_of(c, b, off, w, ne);
        m = mask_of(w);
        f = (mw >> off) & m;
        if (s && f[w-1]) f = f | ~m;
        exp_mrg = (mw & ~(m << off)) | ((sd & m) << off);
        @(negedge clk);
        op_valid_i = 0;
        chk(req, "valid", {63'd0, res_valid_o}, 64'd1);
        chk(req, "store_flag", {63'd0, res_store_o}, {63'd0, st});
        chk(req, "skip_ecc", {63'd0, skip_ecc_o}, {63'd0, ne});
        if (st) chk(req, "merged", merged_o, exp_mrg);
        else begin
            chk(req, "load_data", load_data_o, f);
            chk(req, "load_full", {63'd0, load_full_o}, {63'd0, (cp ? mf : 1'b1)});
        end
    endtask

    localparam logic [63:0] PAT = 64'hF0E1_D2C3_B4A5_9687;
    localparam logic [63:0] POS = 64'h0123_4567_7869_3A2B;

    task automatic t_reset();
        chk("R1", "valid", {63'd0, res_valid_o}, 64'd0);
        chk("R1", "store", {63'd0, res_store_o}, 64'd0);
        chk("R1", "full", {63'd0, load_full_o}, 64'd0);
        chk("R1", "ecc", {63'd0, skip_ecc_o}, 64'd0);
        chk("R1", "ldata", load_data_o, 64'd0);
        chk("R1", "merged", merged_o, 64'd0);
    endtask

    task automatic t_byte_lanes();   // R2
        for (int c = 0; c < 8; c++)
            run_op("R2", 0, 0, 3'(c), 1, 0, 0, 0, 0, 0, 0, PAT, 1, 0);
        @(negedge clk);
        chk("R10", "valid_drops", {63'd0, res_valid_o}, 64'd0);
    endtask

    task automatic t_low_codes();    // R3
        for (int c = 0; c < 4; c++) begin
            run_op("R3", 0, 0, 3'(c), 0, 0, 0, 0, 0, 0, 0, PAT, 1, 0);
            run_op("R3", 0, 0, 3'(c), 0, 1, 0, 0, 0, 0, 0, POS, 1, 0);
        end
    endtask

    task automatic t_high_codes();   // R4
        for (int c = 4; c < 8; c++) begin
            run_op("R4", 0, 0, 3'(c), 0, 0, 0, 0, 0, 0, 0, PAT, 1, 0);
            run_op("R4", 0, 0, 3'(c), 0, 1, 0, 0, 0, 0, 0, POS, 1, 0);
        end
    endtask

    task automatic t_extend();       // R5
        run_op("R5", 0, 0, 3'd7, 1, 1, 0, 0, 0, 0, 0, PAT, 1, 0);
        run_op("R5", 0, 0, 3'd1, 0, 1, 0, 0, 0, 0, 0, PAT, 1, 0);
        run_op("R5", 0, 0, 3'd6, 0, 1, 0, 0, 0, 0, 0, PAT, 1, 0);
        run_op("R5", 0, 0, 3'd3, 1, 1, 0, 0, 0, 0, 0, POS, 1, 0);
        run_op("R5", 0, 0, 3'd6, 0, 0, 0, 0, 0, 0, 0, PAT, 1, 0);
    endtask

    task automatic t_copy();         // R6
        run_op("R6", 0, 0, 3'd0, 0, 0, 1, 0, 0, 0, 0, PAT, 0, 0);
        run_op("R6", 0, 0, 3'd0, 0, 0, 1, 0, 0, 0, 0, PAT, 1, 0);
        run_op("R6", 0, 0, 3'd2, 0, 0, 0, 0, 0, 0, 0, PAT, 0, 0);
    endtask

    task automatic t_src_select();   // R7
        run_op("R7", 0, 1, 3'd0, 0, 0, 0, 3'd5, 1, 1, 1, PAT, 0, 0);
        run_op("R7", 0, 1, 3'd5, 1, 1, 1, 3'd3, 0, 0, 0, PAT, 0, 0);
        run_op("R7", 0, 0, 3'd5, 1, 1, 1, 3'd3, 0, 0, 0, PAT, 0, 0);
        run_op("R7", 1, 1, 3'd0, 0, 0, 0, 3'd4, 1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 64'd0);
    endtask

    task automatic t_store();        // R8
        for (int c = 0; c < 8; c++) begin
            run_op("R8", 1, 0, 3'(c), 0, 0, 0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 64'd0);
            run_op("R8", 1, 0, 3'(c), 1, 0, 0, 0, 0, 0, 0, 64'd0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        end
        run_op("R8", 1, 0, 3'd3, 0, 0, 0, 0, 0, 0, 0, PAT, 1, POS);
    endtask

    task automatic t_noecc();        // R9
        for (int c = 0; c < 8; c++) begin
            run_op("R9", 0, 0, 3'(c), 0, 0, 0, 0, 0, 0, 0, POS, 1, 0);
            run_op("R9", 1, 0, 3'(c), 1, 0, 0, 0, 0, 0, 0, POS, 1, PAT);
        end
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_byte_lanes();
        t_low_codes();
        t_high_codes();
        t_extend();
        t_copy();
        t_src_select();
        t_store();
        t_noecc();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule